// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block sits between two parallel buses, called A and B. Each bus is modelled as three separate vectors: an input, an output and an output enable. The block keeps one storage register for each direction of transfer. The A-to-B register is loaded from the A side and the B-to-A register from the B side. Each direction has its own capture clock.

For each direction, a select input chooses what the block drives onto the far bus. It is either the live value of the near bus or that direction's stored word. The enable for the B side is active high and the enable for the A side is active low. With the B enable high and the A enable low, both buses can be driven from stored data in the same cycle. With the B enable low and the A enable high, the block drives neither bus and only listens.

The value of a pin that the block uses for capture and for the live path is its own output when it drives that pin, and otherwise the external input. A build-time parameter complements the data on both transfer paths.

Top module: `bus_xcvr_reg`

## Requirements
- R1: `b_oe_o` is all ones exactly when `en_ab_i` is high, and `a_oe_o` is all ones exactly when `en_ba_ni` is low; otherwise each is all zeros.
- R2: With `sel_ab_i` low, `b_o` equals the present A pin value in the same cycle. With `sel_ba_i` low, `a_o` equals the present B pin value. No clock edge is needed for either.
- R3: With `sel_ab_i` high, `b_o` shows the A-to-B register. With `sel_ba_i` high, `a_o` shows the B-to-A register.
- R4: On each rising edge of `clk_ab_i`, the A-to-B register loads the A pin value. On each rising edge of `clk_ba_i`, the B-to-A register loads the B pin value. Without its own edge, a register keeps its contents, and an edge on one clock leaves the other register unchanged.
- R5: A pin value is the block's own output when the block drives that bus, and `a_i` or `b_i` otherwise. While B carries live A data, a `clk_ba_i` edge stores the A data into the B-to-A register, and the same holds in the other direction.
- R6: With `en_ab_i` low and `en_ba_ni` high, neither bus is driven. Both registers still capture `a_i` and `b_i` on their edges.
- R7: With `en_ab_i` high, `en_ba_ni` low and both selects high, `b_o` shows the A-to-B register and `a_o` shows the B-to-A register at once. Edges on both clocks in this state swap the two stored words.
- R8: With `INVERT`=1, both transfer paths, live and stored, output the bitwise complement. With `INVERT`=0, the data passes unchanged.
- R9: While `rst_ni` is low, both registers are zero, with no clock needed. After release, the first two rising edges of each capture clock load nothing, and the third edge loads.
- R10: When both buses are driven and both selects are low, the live paths would form a loop. In that case the block uses the external inputs as pin values, so `b_o` follows `a_i` and `a_o` follows `b_i`, and captures take `a_i` and `b_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ab_i | input | 1 | Capture clock of the A-to-B register |
| clk_ba_i | input | 1 | Capture clock of the B-to-A register |
| rst_ni | input | 1 | Asynchronous active-low reset |
| en_ab_i | input | 1 | Drive B bus, active high |
| en_ba_ni | input | 1 | Drive A bus, active low |
| sel_ab_i | input | 1 | B output source: 0 live A, 1 stored |
| sel_ba_i | input | 1 | A output source: 0 live B, 1 stored |
| a_i | input | WIDTH | External value on bus A |
| a_o | output | WIDTH | Value the block offers to bus A |
| a_oe_o | output | WIDTH | Drive enable for bus A |
| b_i | input | WIDTH | External value on bus B |
| b_o | output | WIDTH | Value the block offers to bus B |
| b_oe_o | output | WIDTH | Drive enable for bus B |

## Verification
The enables and the live paths are combinational, so they are due in the same time step as a control or data change. The bench samples them one nanosecond after it drives the inputs. A stored word is due only after the rising edge of its own capture clock, and after a reset release only from the third edge on. Each vector therefore applies its controls, pulses the chosen clocks and samples after the falling edge. The stored words are read back through the stored-select path in a later vector.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

  // Control word seen by the pin resolver; polarities already normalised.
  typedef struct packed {
    logic drive_b;    // block drives bus B
    logic drive_a;    // block drives bus A
    logic stored_ab;  // B output comes from the A-to-B register
    logic stored_ba;  // A output comes from the B-to-A register
  } xcvr_ctrl_t;

  localparam int unsigned XCVR_SYNC_STAGES = 2;

endpackage

// File: rtl/xcvr_capture_reg.sv
module xcvr_capture_reg #(
  parameter int WIDTH       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  logic [SYNC_STAGES-1:0] sync_q, sync_d;
  logic                   ready;
  logic                   load_en;
  logic [WIDTH-1:0]       q_q, q_d;

  // Reset release is synchronised to this register's own clock.
  always_comb begin
    sync_d  = {sync_q[SYNC_STAGES-2:0], 1'b1};
    ready   = sync_q[SYNC_STAGES-1];
    load_en = ready;
    q_d     = load_en ? d_i : q_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      q_q    <= '0;
    end else begin
      sync_q <= sync_d;
      q_q    <= q_d;
    end
  end

  assign q_o = q_q;

  // R4
  capture_follows_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready |=> (q_q == $past(d_i)));

  // R9
  held_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ready |-> (q_q == '0));

endmodule

// File: rtl/xcvr_pin_resolve.sv
module xcvr_pin_resolve
  import xcvr_pkg::*;
#(
  parameter int WIDTH  = 8,
  parameter bit INVERT = 1'b0
) (
  input  xcvr_ctrl_t       ctrl_i,
  input  logic [WIDTH-1:0] a_ext_i,
  input  logic [WIDTH-1:0] b_ext_i,
  input  logic [WIDTH-1:0] q_ab_i,
  input  logic [WIDTH-1:0] q_ba_i,
  output logic [WIDTH-1:0] a_pin_o,
  output logic [WIDTH-1:0] b_pin_o
);

  localparam logic [WIDTH-1:0] XMASK = INVERT ? {WIDTH{1'b1}} : {WIDTH{1'b0}};

  logic [WIDTH-1:0] a_stored, b_stored;
  logic [WIDTH-1:0] a_base, b_base;
  logic             a_live, b_live, loop_hit;

  always_comb begin
    // Pin values that do not depend on the opposite live path.
    a_stored = q_ba_i ^ XMASK;
    b_stored = q_ab_i ^ XMASK;
    a_base   = (ctrl_i.drive_a && ctrl_i.stored_ba) ? a_stored : a_ext_i;
    b_base   = (ctrl_i.drive_b && ctrl_i.stored_ab) ? b_stored : b_ext_i;
    a_live   = ctrl_i.drive_a && !ctrl_i.stored_ba;
    b_live   = ctrl_i.drive_b && !ctrl_i.stored_ab;
    loop_hit = a_live && b_live;
    // A live-driven pin takes the opposite pin; a loop falls back to inputs.
    a_pin_o  = a_live ? (loop_hit ? a_ext_i : (b_base ^ XMASK)) : a_base;
    b_pin_o  = b_live ? (loop_hit ? b_ext_i : (a_base ^ XMASK)) : b_base;
  end

endmodule

// File: rtl/xcvr_dir_mux.sv
module xcvr_dir_mux #(
  parameter int WIDTH  = 8,
  parameter bit INVERT = 1'b0
) (
  input  logic             stored_sel_i,
  input  logic [WIDTH-1:0] live_i,
  input  logic [WIDTH-1:0] stored_i,
  output logic [WIDTH-1:0] y_o
);

  logic [WIDTH-1:0] pick;

  always_comb pick = stored_sel_i ? stored_i : live_i;

  generate
    if (INVERT) begin : g_invert
      assign y_o = ~pick;
    end else begin : g_pass
      assign y_o = pick;
    end
  endgenerate

endmodule

// File: rtl/bus_xcvr_reg.sv
module bus_xcvr_reg
  import xcvr_pkg::*;
#(
  parameter int WIDTH  = 8,
  parameter bit INVERT = 1'b0
) (
  input  logic             clk_ab_i,
  input  logic             clk_ba_i,
  input  logic             rst_ni,
  input  logic             en_ab_i,
  input  logic             en_ba_ni,
  input  logic             sel_ab_i,
  input  logic             sel_ba_i,
  input  logic [WIDTH-1:0] a_i,
  output logic [WIDTH-1:0] a_o,
  output logic [WIDTH-1:0] a_oe_o,
  input  logic [WIDTH-1:0] b_i,
  output logic [WIDTH-1:0] b_o,
  output logic [WIDTH-1:0] b_oe_o
);

  localparam int SYNC_STAGES = XCVR_SYNC_STAGES;

  xcvr_ctrl_t       ctrl;
  logic [WIDTH-1:0] q_ab, q_ba;
  logic [WIDTH-1:0] a_src, b_src;

  always_comb begin
    ctrl.drive_b   = en_ab_i;
    ctrl.drive_a   = !en_ba_ni;
    ctrl.stored_ab = sel_ab_i;
    ctrl.stored_ba = sel_ba_i;
  end

  assign a_oe_o = {WIDTH{ctrl.drive_a}};
  assign b_oe_o = {WIDTH{ctrl.drive_b}};

  xcvr_pin_resolve #(.WIDTH(WIDTH), .INVERT(INVERT)) pins_u (
    .ctrl_i  (ctrl),
    .a_ext_i (a_i),
    .b_ext_i (b_i),
    .q_ab_i  (q_ab),
    .q_ba_i  (q_ba),
    .a_pin_o (a_src),
    .b_pin_o (b_src)
  );

  xcvr_capture_reg #(.WIDTH(WIDTH), .SYNC_STAGES(SYNC_STAGES)) reg_ab_u (
    .clk_i  (clk_ab_i),
    .rst_ni (rst_ni),
    .d_i    (a_src),
    .q_o    (q_ab)
  );

  xcvr_capture_reg #(.WIDTH(WIDTH), .SYNC_STAGES(SYNC_STAGES)) reg_ba_u (
    .clk_i  (clk_ba_i),
    .rst_ni (rst_ni),
    .d_i    (b_src),
    .q_o    (q_ba)
  );

  xcvr_dir_mux #(.WIDTH(WIDTH), .INVERT(INVERT)) mux_ab_u (
    .stored_sel_i (sel_ab_i),
    .live_i       (a_src),
    .stored_i     (q_ab),
    .y_o          (b_o)
  );

  xcvr_dir_mux #(.WIDTH(WIDTH), .INVERT(INVERT)) mux_ba_u (
    .stored_sel_i (sel_ba_i),
    .live_i       (b_src),
    .stored_i     (q_ba),
    .y_o          (a_o)
  );

  // R3
  b_pin_consistent_chk: assert property (@(posedge clk_ba_i) disable iff (!rst_ni)
    (en_ab_i && sel_ab_i) |-> (b_src == b_o));

  // R3
  a_pin_consistent_chk: assert property (@(posedge clk_ab_i) disable iff (!rst_ni)
    (!en_ba_ni && sel_ba_i) |-> (a_src == a_o));

endmodule

// File: tb/bus_xcvr_reg_tb.sv
module bus_xcvr_reg_tb_top;

  localparam int W = 8;

  logic tb_clk = 1'b0;
  logic clk_ab = 1'b0, clk_ba = 1'b0, rst_n = 1'b0;
  logic en_ab = 1'b0, en_ba_n = 1'b1, sel_ab = 1'b0, sel_ba = 1'b0;
  logic [W-1:0] a_in = '0, b_in = '0;
  logic [W-1:0] a_out, a_oe, b_out, b_oe;
  logic [W-1:0] ia_out, ia_oe, ib_out, ib_oe;

  int n_tests = 0;
  int n_fail  = 0;
  int cycles  = 0;
  bit done    = 1'b0;

  always #2 tb_clk = ~tb_clk;  // 250 MHz

  bus_xcvr_reg #(.WIDTH(W), .INVERT(1'b0)) dut_i (
    .clk_ab_i(clk_ab), .clk_ba_i(clk_ba), .rst_ni(rst_n),
    .en_ab_i(en_ab), .en_ba_ni(en_ba_n), .sel_ab_i(sel_ab), .sel_ba_i(sel_ba),
    .a_i(a_in), .a_o(a_out), .a_oe_o(a_oe),
    .b_i(b_in), .b_o(b_out), .b_oe_o(b_oe));

  bus_xcvr_reg #(.WIDTH(W), .INVERT(1'b1)) dut_inv_i (
    .clk_ab_i(clk_ab), .clk_ba_i(clk_ba), .rst_ni(rst_n),
    .en_ab_i(en_ab), .en_ba_ni(en_ba_n), .sel_ab_i(sel_ab), .sel_ba_i(sel_ba),
    .a_i(a_in), .a_o(ia_out), .a_oe_o(ia_oe),
    .b_i(b_in), .b_o(ib_out), .b_oe_o(ib_oe));

  // ctl = {en_ab, en_ba_n, sel_ab, sel_ba}; clk = {pulse_ab, pulse_ba}
  typedef struct packed {
    logic [3:0] ctl;
    logic [7:0] a;
    logic [7:0] b;
    logic [1:0] clk;
    logic       aoe;
    logic [7:0] ea;
    logic       boe;
    logic [7:0] eb;
    logic [7:0] req;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VEC [NV] = '{
    '{4'b0100, 8'h11, 8'h22, 2'b11, 1'b0, 8'h00, 1'b0, 8'h00, 8'd6},  // R6 isolation capture
    '{4'b1011, 8'h33, 8'h44, 2'b00, 1'b1, 8'h22, 1'b1, 8'h11, 8'd7},  // R7 both stored
    '{4'b1100, 8'h5A, 8'h00, 2'b00, 1'b0, 8'h00, 1'b1, 8'h5A, 8'd2},  // R2 live A to B
    '{4'b1100, 8'h5A, 8'h00, 2'b01, 1'b0, 8'h00, 1'b1, 8'h5A, 8'd5},  // R5 B reg takes A
    '{4'b0000, 8'h00, 8'hC3, 2'b10, 1'b1, 8'hC3, 1'b0, 8'h00, 8'd5},  // R5 A reg takes B
    '{4'b1011, 8'hFF, 8'hFF, 2'b00, 1'b1, 8'h5A, 1'b1, 8'hC3, 8'd3},  // R3 readback
    '{4'b1011, 8'hFF, 8'hFF, 2'b11, 1'b1, 8'hC3, 1'b1, 8'h5A, 8'd7},  // R7 swap
    '{4'b0100, 8'h01, 8'h02, 2'b00, 1'b0, 8'h00, 1'b0, 8'h00, 8'd4},  // R4 no edge
    '{4'b1011, 8'h00, 8'h00, 2'b00, 1'b1, 8'hC3, 1'b1, 8'h5A, 8'd4},  // R4 held
    '{4'b0100, 8'h77, 8'h88, 2'b10, 1'b0, 8'h00, 1'b0, 8'h00, 8'd6},  // R6 only A edge
    '{4'b1011, 8'h00, 8'h00, 2'b00, 1'b1, 8'hC3, 1'b1, 8'h77, 8'd4},  // R4 independent
    '{4'b1000, 8'h12, 8'h34, 2'b11, 1'b1, 8'h34, 1'b1, 8'h12, 8'd10}, // R10 loop fallback
    '{4'b1011, 8'h00, 8'h00, 2'b00, 1'b1, 8'h34, 1'b1, 8'h12, 8'd10}, // R10 captured inputs
    '{4'b1010, 8'h99, 8'h99, 2'b00, 1'b1, 8'h12, 1'b1, 8'h12, 8'd2}   // R2 live from stored B
  };

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [3:0] ctl, input logic [W-1:0] a, input logic [W-1:0] b);
    {en_ab, en_ba_n, sel_ab, sel_ba} = ctl;
    a_in = a;
    b_in = b;
    #1;
  endtask

  task automatic pulse(input logic [1:0] m);
    clk_ab = m[1];
    clk_ba = m[0];
    #2;
    clk_ab = 1'b0;
    clk_ba = 1'b0;
    #2;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  always @(posedge tb_clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=<100000", cycles);
      finish_run();
    end
  end

  initial begin
    // R9 reset state, read through stored selects; R1 enables
    drive(4'b1011, 8'hAA, 8'h55);
    check("R9 reset a_out", a_out, 8'h00);
    check("R9 reset b_out", b_out, 8'h00);
    check("R1 a_oe", a_oe, 8'hFF);
    check("R1 b_oe", b_oe, 8'hFF);
    #3 rst_n = 1'b1;
    #2;
    // R9 first two edges after release load nothing
    drive(4'b0100, 8'hAA, 8'h55);
    pulse(2'b11);
    pulse(2'b11);
    check("R1 a_oe off", a_oe, 8'h00);
    check("R1 b_oe off", b_oe, 8'h00);
    drive(4'b1011, 8'h00, 8'h00);
    check("R9 no load a", a_out, 8'h00);
    check("R9 no load b", b_out, 8'h00);
    // R9 third edge loads
    drive(4'b0100, 8'hAA, 8'h55);
    pulse(2'b11);
    drive(4'b1011, 8'h00, 8'h00);
    check("R9 third edge b", b_out, 8'hAA);
    check("R9 third edge a", a_out, 8'h55);

    for (int i = 0; i < NV; i++) begin
      string tag;
      tag = $sformatf("R%0d vec%0d", VEC[i].req, i);
      drive(VEC[i].ctl, VEC[i].a, VEC[i].b);
      if (VEC[i].clk != 2'b00) pulse(VEC[i].clk);
      check({tag, " a_oe"}, a_oe, {W{VEC[i].aoe}});
      check({tag, " b_oe"}, b_oe, {W{VEC[i].boe}});
      if (VEC[i].aoe) check({tag, " a_out"}, a_out, VEC[i].ea);
      if (VEC[i].boe) check({tag, " b_out"}, b_out, VEC[i].eb);
    end

    // R8 inverting variant: stored and live paths complemented
    drive(4'b0100, 8'h0F, 8'h3C);
    pulse(2'b11);
    drive(4'b1011, 8'h00, 8'h00);
    check("R8 inv stored b", ib_out, 8'hF0);
    check("R8 inv stored a", ia_out, 8'hC3);
    check("R8 pass stored b", b_out, 8'h0F);
    drive(4'b1100, 8'h0F, 8'h00);
    check("R8 inv live b", ib_out, 8'hF0);
    drive(4'b0000, 8'h00, 8'h3C);
    check("R8 inv live a", ia_out, 8'hC3);

    // R9 asynchronous clear mid-run
    drive(4'b1011, 8'h00, 8'h00);
    rst_n = 1'b0;
    #1;
    check("R9 async clear a", a_out, 8'h00);
    check("R9 async clear b", b_out, 8'h00);
    rst_n = 1'b1;
    #4;
    finish_run();
  end

endmodule